// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block turns one fast oscillator clock into the pair of see-saw clock phases that an early 8-bit processor needs. A counter walks through nine states per processor cycle, so each phase repeats at one ninth of the oscillator rate; an 18 MHz oscillator therefore yields a 2 MHz processor clock. Phase 1 is high for the first two oscillator periods of the cycle and phase 2 for the next five. The last two periods are dead time in which both phases are low, so the two phases are never high together.

Around the phase sequencer the block conditions the processor's control inputs. An active-low push-button reset is brought through a synchronizer and becomes an active-high reset output. A ready input is re-timed so that it only changes where phase 2 falls. A machine-cycle sync input from the processor is sampled at that same point, and if it was high, an active-low status strobe covers the phase-1 interval that follows. Two auxiliary outputs are also provided: a logic-level copy of phase 2 and an undivided copy of the oscillator.

Top module: `twophase_clkgen`

## Requirements
- R1: With `rst` low, `ph1` rises exactly once every `DIV` (default 9) `clk` cycles.
- R2: `ph1` and `ph2` are never high together.
- R3: In each cycle `ph1` is high for 2 `clk` periods, then `ph2` is high for the next 5, then both are low for 2. The first `clk` edge after `rst` is released starts a `ph1` interval.
- R4: `ph2_ttl` equals `ph2` in every `clk` period.
- R5: `osc_out` equals `clk` at all times: it is high in the high half of each `clk` period and low in the low half.
- R6: `rst_out` is 1 while `rst` is high. Otherwise it shows the inverse of `btn_rst_n`, delayed through 2 samples that are each taken at a `ph2` falling edge. It changes at no other edge.
- R7: `rdy_out` is 0 while `rst` is high. Otherwise it takes the value of `rdy_in` sampled at the edge where `ph2` falls, and holds that value until the next such edge. Changes of `rdy_in` at any other time have no effect on `rdy_out`.
- R8: `sync_in` is sampled at each `ph2` falling edge. `stb_n` is 0 for exactly the `ph1` interval that follows a sample of 1, and is 1 at all other times.
- R9: While `rst` is high, `ph1`, `ph2` and `ph2_ttl` are 0 and `stb_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| btn_rst_n | input | 1 | Push-button reset, active low, idles high |
| rdy_in | input | 1 | Ready request from the system |
| sync_in | input | 1 | Machine-cycle start marker from the processor |
| ph1 | output | 1 | Clock phase 1 |
| ph2 | output | 1 | Clock phase 2 |
| ph2_ttl | output | 1 | Logic-level copy of phase 2 |
| osc_out | output | 1 | Undivided oscillator copy |
| rst_out | output | 1 | Processor reset, active high |
| rdy_out | output | 1 | Re-timed ready to the processor |
| stb_n | output | 1 | Status strobe, active low |

## Verification
The hardest thing to show from the ports is that a `rdy_in`, `sync_in` or `btn_rst_n` edge arriving in the middle of a cycle does nothing until the next `ph2` fall. The stimulus reaches this by changing those inputs on patterns whose periods are prime and do not divide 9. Over a few hundred cycles, each input therefore changes at every count position. A cycle-by-cycle model then compares every output. The button is held low across several cycles and then released, so the two-sample delay shows up on `rst_out`. A second power-on reset in the middle of the run checks that the sequence restarts on a clean `ph1` interval.

// File: rtl/twophase_pkg.sv
package twophase_pkg;

   typedef struct packed {
      logic p1;
      logic p2;
   } phase_pair_t;

   // Phase decode for a given count position within the cycle.
   function automatic phase_pair_t phase_at(int pos, int p1_len, int p2_len);
      phase_pair_t r;
      r.p1 = (pos < p1_len);
      r.p2 = (pos >= p1_len) && (pos < p1_len + p2_len);
      return r;
   endfunction

endpackage

// File: rtl/tp_phase_seq.sv
module tp_phase_seq #(
   parameter int DIV            = 9,
   parameter int PH1_LEN        = 2,
   parameter int PH2_LEN        = 5,
   parameter bit TTL_REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst,
   output logic ph1,
   output logic ph2,
   output logic ph2_ttl,
   output logic in_ph1_next,
   output logic p2_fall_tick
);
   import twophase_pkg::*;

   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST_C  = CW'(DIV - 1);
   localparam logic [CW-1:0] FALL_C  = CW'(PH1_LEN + PH2_LEN);

   initial begin
      assert (PH1_LEN >= 1 && PH2_LEN >= 1)
         else $error("tp_phase_seq: phase lengths must be at least 1");
      assert (PH1_LEN + PH2_LEN < DIV)
         else $error("tp_phase_seq: no dead time left in the cycle");
   end

   logic [CW-1:0] cnt_q;
   phase_pair_t   dec;
   logic          ph1_q, ph2_q;

   always_comb dec = phase_at(int'(cnt_q), PH1_LEN, PH2_LEN);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         ph1_q <= 1'b0;
         ph2_q <= 1'b0;
      end else begin
         cnt_q <= (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
         ph1_q <= dec.p1;
         ph2_q <= dec.p2;
      end
   end

   assign ph1          = ph1_q;
   assign ph2          = ph2_q;
   assign in_ph1_next  = dec.p1;
   assign p2_fall_tick = (cnt_q == FALL_C);

   generate
      if (TTL_REGISTERED) begin : g_ttl_reg
         logic ttl_q;
         always_ff @(posedge clk) begin
            if (rst) ttl_q <= 1'b0;
            else     ttl_q <= dec.p2;
         end
         assign ph2_ttl = ttl_q;
      end else begin : g_ttl_wire
         assign ph2_ttl = ph2_q;
      end
   endgenerate

endmodule

// File: rtl/tp_sync_chain.sv
module tp_sync_chain #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic d,
   output logic q
);
   initial begin
      assert (STAGES >= 1) else $error("tp_sync_chain: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst)     chain_q[0] <= RESET_VAL;
      else if (en) chain_q[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst)     chain_q[i] <= RESET_VAL;
            else if (en) chain_q[i] <= chain_q[i-1];
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/tp_strobe.sv
module tp_strobe (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic in_ph1_next,
   input  logic sync_in,
   input  logic rdy_in,
   output logic stb_n,
   output logic rdy_out
);
   logic armed_q, stb_n_q, rdy_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
         stb_n_q <= 1'b1;
         rdy_q   <= 1'b0;
      end else begin
         if (tick) begin
            armed_q <= sync_in;
            rdy_q   <= rdy_in;
         end
         stb_n_q <= ~(armed_q & in_ph1_next);
      end
   end

   assign stb_n   = stb_n_q;
   assign rdy_out = rdy_q;

endmodule

// File: rtl/twophase_clkgen.sv
module twophase_clkgen #(
   parameter int DIV            = 9,
   parameter int PH1_LEN        = 2,
   parameter int PH2_LEN        = 5,
   parameter int RST_STAGES     = 2,
   parameter bit TTL_REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_rst_n,
   input  logic rdy_in,
   input  logic sync_in,
   output logic ph1,
   output logic ph2,
   output logic ph2_ttl,
   output logic osc_out,
   output logic rst_out,
   output logic rdy_out,
   output logic stb_n
);
   logic ph1_next, fall_tick;

   tp_phase_seq #(
      .DIV(DIV), .PH1_LEN(PH1_LEN), .PH2_LEN(PH2_LEN),
      .TTL_REGISTERED(TTL_REGISTERED)
   ) u_seq (
      .clk(clk), .rst(rst),
      .ph1(ph1), .ph2(ph2), .ph2_ttl(ph2_ttl),
      .in_ph1_next(ph1_next), .p2_fall_tick(fall_tick)
   );

   tp_sync_chain #(.STAGES(RST_STAGES), .RESET_VAL(1'b1)) u_rst_sync (
      .clk(clk), .rst(rst), .en(fall_tick), .d(~btn_rst_n), .q(rst_out)
   );

   tp_strobe u_stb (
      .clk(clk), .rst(rst), .tick(fall_tick), .in_ph1_next(ph1_next),
      .sync_in(sync_in), .rdy_in(rdy_in), .stb_n(stb_n), .rdy_out(rdy_out)
   );

   assign osc_out = clk;

endmodule

// File: rtl/twophase_clkgen_chk.sv
module twophase_clkgen_chk #(
   parameter int DIV = 9
) (
   input logic clk,
   input logic rst,
   input logic ph1,
   input logic ph2,
   input logic ph2_ttl,
   input logic rst_out,
   input logic rdy_out,
   input logic stb_n
);
   logic ph1_d, seen;
   int   gap;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph1_d <= 1'b0;
         seen  <= 1'b0;
         gap   <= 0;
      end else begin
         ph1_d <= ph1;
         if (ph1 && !ph1_d) begin
            seen <= 1'b1;
            gap  <= 0;
         end else begin
            gap  <= gap + 1;
         end
      end
   end

   a_r1_period: assert property (@(posedge clk) disable iff (rst)
      (ph1 && !ph1_d && seen) |-> (gap == DIV - 1));

   a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
      !(ph1 && ph2));

   a_r3_ph2_after_ph1: assert property (@(posedge clk) disable iff (rst)
      $fell(ph1) |-> $rose(ph2));

   a_r4_ttl_copy: assert property (@(posedge clk) disable iff (rst)
      ph2_ttl == ph2);

   a_r6_rst_moves_at_fall: assert property (@(posedge clk) disable iff (rst)
      !$fell(ph2) |-> $stable(rst_out));

   a_r7_rdy_moves_at_fall: assert property (@(posedge clk) disable iff (rst)
      !$fell(ph2) |-> $stable(rdy_out));

   a_r8_stb_inside_ph1: assert property (@(posedge clk) disable iff (rst)
      !stb_n |-> ph1);

endmodule

bind twophase_clkgen twophase_clkgen_chk #(.DIV(DIV)) u_chk (
   .clk(clk), .rst(rst), .ph1(ph1), .ph2(ph2), .ph2_ttl(ph2_ttl),
   .rst_out(rst_out), .rdy_out(rdy_out), .stb_n(stb_n)
);

// File: tb/twophase_clkgen_test.sv
module twophase_clkgen_test;
   localparam int DIV = 9;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic btn_rst_n = 1'b1;
   logic rdy_in = 1'b0;
   logic sync_in = 1'b0;
   logic ph1, ph2, ph2_ttl, osc_out, rst_out, rdy_out, stb_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   twophase_clkgen uut (
      .clk(clk), .rst(rst), .btn_rst_n(btn_rst_n), .rdy_in(rdy_in),
      .sync_in(sync_in), .ph1(ph1), .ph2(ph2), .ph2_ttl(ph2_ttl),
      .osc_out(osc_out), .rst_out(rst_out), .rdy_out(rdy_out), .stb_n(stb_n)
   );

   always #10 clk = ~clk;

   // Reference model: position in the 9-period cycle and expected outputs.
   int pos = 0;
   int e_ph1 = 0, e_ph2 = 0, e_rdy = 0, e_stb = 1, e_rst = 1;
   int smp_q[$];
   int armed = 0;

   always @(posedge clk) begin
      if (rst) begin
         pos = 0; e_ph1 = 0; e_ph2 = 0; e_rdy = 0; e_stb = 1; e_rst = 1;
         armed = 0; smp_q = '{1, 1};
      end else begin
         e_ph1 = (pos < 2) ? 1 : 0;
         e_ph2 = (pos >= 2 && pos < 7) ? 1 : 0;
         e_stb = (armed == 1 && pos < 2) ? 0 : 1;
         if (pos == 7) begin
            e_rdy = rdy_in;
            armed = sync_in;
            smp_q.push_back(btn_rst_n ? 0 : 1);
            e_rst = smp_q.pop_front();
            e_rst = smp_q[0];
         end
         pos = (pos + 1) % DIV;
      end
   end

   task automatic chk(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R2 overlap", (ph1 && ph2) ? 1 : 0, 0);
      chk(rst ? "R9 ph1" : "R1/R3 ph1", ph1, e_ph1);
      chk(rst ? "R9 ph2" : "R3 ph2", ph2, e_ph2);
      chk("R4 ph2_ttl", ph2_ttl, e_ph2);
      chk("R6 rst_out", rst_out, e_rst);
      chk("R7 rdy_out", rdy_out, e_rdy);
      chk(rst ? "R9 stb_n" : "R8 stb_n", stb_n, e_stb);
   endtask

   int cyc = 0;

   task automatic step();
      @(negedge clk);
      compare_all();
      cyc++;
      // prime periods so every input lands on every count position
      rdy_in  = (((cyc * 7) % 13) < 6) ? 1'b1 : 1'b0;
      sync_in = (((cyc * 5) % 11) < 3) ? 1'b1 : 1'b0;
   endtask

   int r1_rises = 0;
   int r1_last  = -1;
   int r1_cyc   = 0;

   initial begin
      for (int i = 0; i < 4; i++) step();
      rst = 1'b0;
      // R3: first ph1 interval begins at the first edge after release
      @(negedge clk); compare_all(); chk("R3 first ph1", ph1, 1);
      for (int i = 0; i < 200; i++) step();
      // R5: osc copy in both halves of a clock period
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); #5; chk("R5 osc high", osc_out, 1);
         @(negedge clk); #5; chk("R5 osc low", osc_out, 0);
      end
      // R6: press button across several cycles, then release
      @(negedge clk); btn_rst_n = 1'b0;
      for (int i = 0; i < 60; i++) step();
      chk("R6 rst_out asserted by button", rst_out, 1);
      btn_rst_n = 1'b1;
      for (int i = 0; i < 60; i++) step();
      chk("R6 rst_out released", rst_out, 0);
      // mid-run power-on reset
      @(negedge clk); rst = 1'b1;
      for (int i = 0; i < 5; i++) step();
      @(negedge clk); rst = 1'b0;
      // R1: count ph1 rises over a long window
      for (int i = 0; i < 300; i++) begin
         step();
         if (!rst) begin
            r1_cyc++;
            if (ph1 && r1_last == 0) begin
               if (r1_rises > 0) chk("R1 rise spacing", r1_cyc, DIV);
               r1_rises++;
               r1_cyc = 0;
            end
            r1_last = ph1;
         end
      end
      chk("R1 rises seen", (r1_rises >= 30) ? 1 : 0, 1);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule